// File: doc/BRIEF.md
# Receive Symbol Status Monitor

This block sits beside a 100 Mb/s receive path. It looks at every decoded 5-bit code-group that arrives while a frame is being received. It remembers two error conditions in latching-high bits of a 16-bit management status word:

- **Halt:** a Halt code-group was seen inside a frame.
- **Premature end:** two Idle code-groups arrived back to back inside a frame.

The same word also reports two live conditions:

- **Auto-negotiation complete:** qualified by the auto-negotiation enable.
- **Receive signal detect:** qualified by the speed mode.

A management agent reads the word through a simple read port. The read returns the word one cycle later and clears the two error bits. An error event that lands in the same cycle as the read is kept for the next read. Reads of any other register address return zero and leave the error bits untouched.

Top module: `rxmon_status_reg`

## Requirements
- R1: A code-group equal to 5'b00100 (Halt), with `sym_valid` high and `frame_active` high, sets status bit 6.
- R2: Two Idle code-groups (5'b11111) that are valid, inside a frame and with no other valid code-group between them set status bit 5. Any of the following before the second Idle keeps bit 5 clear: a valid non-Idle code-group, or `frame_active` low for at least one cycle.
- R3: Bits 6 and 5, once set, stay at 1 until the block is reset or the status register is read. They stay set even after the condition has gone away.
- R4: A read is `rd_en` high with `rd_addr` equal to `REG_ADDR` (default 17). It places the status word on `rd_data` one cycle later and clears bits 6 and 5. A read of any other address returns 0 and clears nothing.
- R5: If a Halt or premature-end event occurs in the same cycle as a read, the read returns the value from before the event, and the bit is set afterwards.
- R6: Bit 4 reads 1 only when both `an_enable` and `an_done` are high at the read cycle; otherwise it reads 0.
- R7: Bit 3 reads `sig_detect` when `speed_100` is high, and reads 0 when `speed_100` is low (10 Mb/s mode).
- R8: Bits 15..7 and 2..0 always read 0. Synchronous reset clears bits 6 and 5 and drives `rd_data` to 0.
- R9: Code-groups with `sym_valid` low, and code-groups presented while `frame_active` is low, set no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_code | input | 5 | Decoded code-group |
| sym_valid | input | 1 | Code-group strobe |
| frame_active | input | 1 | High while a frame is being received |
| speed_100 | input | 1 | 1 = 100 Mb/s mode, 0 = 10 Mb/s mode |
| an_enable | input | 1 | Auto-negotiation enable from control |
| an_done | input | 1 | Auto-negotiation finished |
| sig_detect | input | 1 | Receive signal present |
| rd_en | input | 1 | Management read strobe |
| rd_addr | input | ADDR_W | Management register address |
| rd_data | output | 16 | Read data, valid the cycle after `rd_en` |

## Verification
The bench exercises the following corner cases, each paired with the fault it exposes:

- **Single Idle, then a new frame, then another Idle.** A tracker that is not cleared between frames would report a false premature end here.
- **An Idle, a data code-group, then another Idle.** A design that counts Idles instead of looking for adjacent ones would set bit 5.
- **Halt and Idle pairs outside a frame, and code-groups with the strobe low.** A design that qualifies badly would latch on these.
- **An event in the same cycle as a read.** A design where the clear wins would lose the event.
- **Reads of a foreign address.** A design that does not compare the address would wipe the error bits.

Random traffic mixed with these cases is compared against a bench-side model of every bit.

// File: rtl/rxmon_pkg.sv
package rxmon_pkg;

    localparam int CODE_W   = 5;
    localparam int STATUS_W = 16;
    localparam int N_STICKY = 2;

    localparam logic [CODE_W-1:0] CG_HALT = 5'b00100;
    localparam logic [CODE_W-1:0] CG_IDLE = 5'b11111;

    // field positions inside the status word
    localparam int POS_HALT  = 6;
    localparam int POS_PREM  = 5;
    localparam int POS_ANC   = 4;
    localparam int POS_SIGDT = 3;

    // sticky slot ordering
    localparam int SLOT_HALT = 0;
    localparam int SLOT_PREM = 1;

    typedef struct packed {
        logic prem;
        logic halt;
    } sym_evt_t;

    typedef struct packed {
        logic anc;
        logic sigdt;
    } live_stat_t;

    function automatic int sticky_pos(input int slot);
        return (slot == SLOT_HALT) ? POS_HALT : POS_PREM;
    endfunction

    function automatic logic [STATUS_W-1:0] build_status(
        input logic [N_STICKY-1:0] sticky,
        input live_stat_t          live
    );
        logic [STATUS_W-1:0] w;
        w = '0;
        for (int i = 0; i < N_STICKY; i++) begin
            w[sticky_pos(i)] = sticky[i];
        end
        w[POS_ANC]   = live.anc;
        w[POS_SIGDT] = live.sigdt;
        return w;
    endfunction

endpackage

// File: rtl/rxmon_sym_check.sv
module rxmon_sym_check
    import rxmon_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] sym_code,
    input  logic              sym_valid,
    input  logic              frame_active,
    output sym_evt_t          evt
);

    logic in_frame_sym;
    logic is_idle;
    logic last_was_idle;

    assign in_frame_sym = sym_valid && frame_active;
    assign is_idle      = (sym_code == CG_IDLE);

    always_ff @(posedge clk) begin
        if (rst || !frame_active) begin
            last_was_idle <= 1'b0;
        end else if (sym_valid) begin
            last_was_idle <= is_idle;
        end
    end

    always_comb begin
        evt      = '0;
        evt.halt = in_frame_sym && (sym_code == CG_HALT);
        evt.prem = in_frame_sym && is_idle && last_was_idle;
    end

endmodule

// File: rtl/rxmon_sticky.sv
module rxmon_sticky #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set,
    input  logic             clr,
    output logic [WIDTH-1:0] q
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= 1'b0;
            end else begin
                q[i] <= (q[i] && !clr) || set[i];
            end
        end
    end

endmodule

// File: rtl/rxmon_status_reg.sv
module rxmon_status_reg
    import rxmon_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int REG_ADDR = 17
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CODE_W-1:0]   sym_code,
    input  logic                sym_valid,
    input  logic                frame_active,
    input  logic                speed_100,
    input  logic                an_enable,
    input  logic                an_done,
    input  logic                sig_detect,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [STATUS_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] MY_ADDR = REG_ADDR[ADDR_W-1:0];

    sym_evt_t              evt;
    logic [N_STICKY-1:0]   evt_vec;
    logic [N_STICKY-1:0]   sticky_q;
    live_stat_t            live;
    logic                  hit;

    assign hit = rd_en && (rd_addr == MY_ADDR);

    rxmon_sym_check u_check (
        .clk          (clk),
        .rst          (rst),
        .sym_code     (sym_code),
        .sym_valid    (sym_valid),
        .frame_active (frame_active),
        .evt          (evt)
    );

    always_comb begin
        evt_vec            = '0;
        evt_vec[SLOT_HALT] = evt.halt;
        evt_vec[SLOT_PREM] = evt.prem;
    end

    rxmon_sticky #(.WIDTH(N_STICKY)) u_sticky (
        .clk (clk),
        .rst (rst),
        .set (evt_vec),
        .clr (hit),
        .q   (sticky_q)
    );

    always_comb begin
        live.anc   = an_enable && an_done;
        live.sigdt = speed_100 && sig_detect;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= hit ? build_status(sticky_q, live) : '0;
        end
    end

endmodule

// File: rtl/rxmon_status_chk.sv
module rxmon_status_chk
    import rxmon_pkg::*;
#(
    parameter int ADDR_W   = 5,
    parameter int REG_ADDR = 17
) (
    input logic                clk,
    input logic                rst,
    input logic [CODE_W-1:0]   sym_code,
    input logic                sym_valid,
    input logic                frame_active,
    input logic                speed_100,
    input logic                an_enable,
    input logic                an_done,
    input logic                sig_detect,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_addr,
    input logic [STATUS_W-1:0] rd_data,
    input logic [N_STICKY-1:0] sticky_q
);

    logic hit_c;
    logic halt_in;

    assign hit_c   = rd_en && (rd_addr == REG_ADDR[ADDR_W-1:0]);
    assign halt_in = sym_valid && frame_active && (sym_code == CG_HALT);

    // R1
    halt_sets_chk: assert property (@(posedge clk) disable iff (rst)
        halt_in |=> sticky_q[SLOT_HALT]);

    // R3
    halt_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (sticky_q[SLOT_HALT] && !hit_c) |=> sticky_q[SLOT_HALT]);

    // R3
    prem_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (sticky_q[SLOT_PREM] && !hit_c) |=> sticky_q[SLOT_PREM]);

    // R4
    read_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_c && !halt_in) |=> !sticky_q[SLOT_HALT]);

    // R5
    read_old_value_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_c && sticky_q[SLOT_HALT]) |=> rd_data[POS_HALT]);

    // R6
    anc_field_chk: assert property (@(posedge clk) disable iff (rst)
        hit_c |=> (rd_data[POS_ANC] == $past(an_enable && an_done)));

    // R7
    sigdt_field_chk: assert property (@(posedge clk) disable iff (rst)
        hit_c |=> (rd_data[POS_SIGDT] == $past(speed_100 && sig_detect)));

    // R8
    reserved_zero_chk: assert property (@(posedge clk)
        (rd_data[15:7] == '0) && (rd_data[2:0] == '0));

endmodule

bind rxmon_status_reg rxmon_status_chk #(
    .ADDR_W   (ADDR_W),
    .REG_ADDR (REG_ADDR)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sym_code     (sym_code),
    .sym_valid    (sym_valid),
    .frame_active (frame_active),
    .speed_100    (speed_100),
    .an_enable    (an_enable),
    .an_done      (an_done),
    .sig_detect   (sig_detect),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .sticky_q     (sticky_q)
);

// File: tb/tb_rxmon_status_reg.sv
`timescale 1ns/1ps
module tb_rxmon_status_reg;

    localparam int AW = 5;
    localparam logic [AW-1:0] ADDR  = 5'd17;
    localparam logic [AW-1:0] OTHER = 5'd1;
    localparam logic [4:0] HALT = 5'b00100;
    localparam logic [4:0] IDLE = 5'b11111;
    localparam logic [4:0] DATA = 5'b01010;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  sym_code;
    logic        sym_valid, frame_active, speed_100, an_enable, an_done, sig_detect;
    logic        rd_en;
    logic [AW-1:0] rd_addr;
    logic [15:0] rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // bench model
    bit m_halt, m_prem, m_prev_idle;

    always #2.5 clk = ~clk;

    rxmon_status_reg #(.ADDR_W(AW), .REG_ADDR(17)) dut (
        .clk(clk), .rst(rst), .sym_code(sym_code), .sym_valid(sym_valid),
        .frame_active(frame_active), .speed_100(speed_100), .an_enable(an_enable),
        .an_done(an_done), .sig_detect(sig_detect), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    function automatic logic [15:0] exp_word(input bit h, input bit p,
                                             input bit ane, input bit and_,
                                             input bit spd, input bit sd);
        logic [15:0] w = '0;
        w[6] = h;
        w[5] = p;
        w[4] = ane & and_;
        w[3] = spd & sd;
        return w;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive one cycle at negedge; model the edge; check result if a read was issued
    task automatic cyc(input logic [4:0] c, input bit v, input bit f,
                       input bit rd, input logic [AW-1:0] a, input string tag);
        logic [15:0] exp;
        bit hit, ev_h, ev_p;
        sym_code = c; sym_valid = v; frame_active = f; rd_en = rd; rd_addr = a;
        hit  = rd && (a == ADDR);
        exp  = hit ? exp_word(m_halt, m_prem, an_enable, an_done, speed_100, sig_detect) : 16'h0;
        ev_h = v && f && (c == HALT);
        ev_p = v && f && (c == IDLE) && m_prev_idle;
        m_halt = (m_halt && !hit) || ev_h;
        m_prem = (m_prem && !hit) || ev_p;
        if (!f) m_prev_idle = 0;
        else if (v) m_prev_idle = (c == IDLE);
        @(posedge clk);
        @(negedge clk);
        if (rd) check(tag, rd_data, exp);
    endtask

    task automatic sym(input logic [4:0] c, input bit v, input bit f);
        cyc(c, v, f, 1'b0, ADDR, "");
    endtask

    task automatic rd(input string tag, input logic [15:0] exp);
        cyc(DATA, 1'b0, 1'b0, 1'b1, ADDR, tag);
        check(tag, rd_data, exp);   // double-check against the directed value
    endtask

    task automatic do_reset();
        rst = 1'b1;
        sym_code = '0; sym_valid = 0; frame_active = 0; rd_en = 0; rd_addr = ADDR;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_halt = 0; m_prem = 0; m_prev_idle = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: timeout actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        speed_100 = 1; an_enable = 0; an_done = 0; sig_detect = 0;
        do_reset();
        // R8 reset state
        check("R8 reset", rd_data, 16'h0);
        rd("R8 reset read", 16'h0000);

        // R6 / R7 live bits
        an_enable = 1; an_done = 1; sig_detect = 1; speed_100 = 1;
        rd("R6 R7 both set", 16'h0018);
        an_enable = 0;
        rd("R6 an disabled", 16'h0008);
        an_enable = 1; speed_100 = 0;
        rd("R7 10M mode", 16'h0010);
        an_enable = 0; an_done = 0; sig_detect = 0; speed_100 = 1;

        // R1 halt in frame, R4 clear on read
        sym(DATA, 1, 1); sym(HALT, 1, 1); sym(DATA, 1, 1); sym(DATA, 0, 0);
        rd("R1 halt latched", 16'h0040);
        rd("R4 cleared after read", 16'h0000);

        // R9 halt outside frame / strobe low
        sym(HALT, 1, 0); sym(HALT, 0, 1); sym(IDLE, 1, 0); sym(IDLE, 1, 0);
        rd("R9 ignored symbols", 16'h0000);

        // R2 single idle, frame end, idle in new frame
        sym(DATA, 1, 1); sym(IDLE, 1, 1); sym(DATA, 0, 0); sym(IDLE, 1, 1); sym(DATA, 1, 1);
        rd("R2 idle split by frame gap", 16'h0000);
        // R2 idle, data, idle
        sym(IDLE, 1, 1); sym(DATA, 1, 1); sym(IDLE, 1, 1); sym(DATA, 0, 0);
        rd("R2 idle split by data", 16'h0000);
        // R2 double idle with an invalid cycle between
        sym(DATA, 1, 1); sym(IDLE, 1, 1); sym(DATA, 0, 1); sym(IDLE, 1, 1); sym(DATA, 0, 0);
        rd("R2 double idle", 16'h0020);

        // R3 persistence, R4 foreign address
        sym(HALT, 1, 1);
        for (int i = 0; i < 20; i++) sym(DATA, 1, 1);
        sym(DATA, 0, 0);
        cyc(DATA, 0, 0, 1, OTHER, "R4 foreign address");
        check("R4 foreign address value", rd_data, 16'h0000);
        rd("R3 halt still latched", 16'h0040);

        // R5 collision: halt in the same cycle as the read
        cyc(HALT, 1, 1, 1, ADDR, "R5 read during event");
        check("R5 old value returned", rd_data, 16'h0000);
        rd("R5 event kept", 16'h0040);

        // R8 reset clears latch
        sym(HALT, 1, 1);
        do_reset();
        rd("R8 reset clears latch", 16'h0000);

        // random traffic against the model
        seed = $urandom(32'd1893);
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] c;
            int unsigned r = $urandom % 8;
            c = (r < 3) ? IDLE : (r == 3) ? HALT : 5'($urandom);
            if (i % 97 == 0) begin
                an_enable = 1'($urandom); an_done = 1'($urandom);
                speed_100 = 1'($urandom); sig_detect = 1'($urandom);
            end
            cyc(c, ($urandom % 4) != 0, ($urandom % 16) != 0,
                ($urandom % 10) == 0, (($urandom % 4) == 0) ? OTHER : ADDR,
                "R1 R2 R3 R4 R5 R6 R7 R9 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule